// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the serial front end that gives a host access to six 8-bit control registers over a two-wire bus in the I2C style. It samples the bus clock and data lines with the core clock, recognises start and stop conditions, and matches a 7-bit device address. It answers on the data line only through an open-drain pull-down request. Two strap inputs set the low two address bits, so up to four of these slaves can share one bus.

A write transfer sends the device address, then a register index, then any number of data bytes. The data bytes land in consecutive registers. A read transfer follows a write phase that set the index, usually after a repeated start. It streams bytes from the parallel read-back inputs, starting at the stored index. The register contents are always visible on a flat parallel output bus. The read-back bus is separate, so the surrounding logic chooses what a read returns, either the written values or live status.

Top module: `twowire_ctl_slave`

## Requirements
- R1: The slave answers only the 7-bit address whose bits 6..0 are 1,0,0,0,0,`strap_hi`,`strap_lo`. For that address it pulls SDA low during the ninth clock of the address byte. Any other address gets no pull-down, and the slave ignores the bus until the next start.
- R2: In a write, the byte after the address is the register index. Each following data byte is acknowledged and is stored into register `index + k` (k = 0, 1, ...). The store is visible on `reg_bus` (register i at bits `8*i+7 : 8*i`) by the end of that byte's acknowledge clock.
- R3: An index of 6 or more is not acknowledged. The slave goes idle, so later data bytes in the same transfer get no acknowledge and change no register.
- R4: A read (R/W bit = 1, bit 0 of the address byte) returns `rd_bus` bytes MSB first, starting at the index set by the last write phase. The index advances after each byte that the master acknowledges.
- R5: A read that passes register 5 keeps returning register 5 until the master answers with a NACK. The slave then releases SDA and goes idle.
- R6: A write that passes register 5 keeps writing register 5, so the last data byte of the transfer ends up there.
- R7: A stop at any point returns the slave to idle, and a partly received data byte is discarded. A start at any point restarts address reception.
- R8: A stop followed by a start within the same SCL high period is handled, and the transfer that follows is served normally.
- R9: After reset all registers read 0 on `reg_bus`, SDA is released, and the register index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_hi | input | 1 | Sets address bit 1 |
| strap_lo | input | 1 | Sets address bit 0 |
| rd_bus | input | 48 | Read-back values, register i at bits 8*i+7:8*i |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_bus | output | 48 | Register contents, register i at bits 8*i+7:8*i |

## Verification
The assertions assume that SDA changes only while the synchronised SCL is low, except for deliberate start and stop edges. They also assume that SCL high and low phases last several core clocks, so each edge is seen once after the two-flop synchroniser. The bench master keeps every phase ten core clocks long. It moves SDA a few clocks after each SCL fall, and it waits long enough before a repeated start for the slave's own pull-down to drop first. Directed cases cover the four strap addresses, bad indices, runs past the last register, aborted transfers and a stop-then-start within one SCL high period. Seeded random transfers then mix writes and reads of random start index and length.

// File: rtl/twr_pkg.sv
// Shared types for the two-wire control slave.
// Assumes byte-wide transfers; the register count is set at the top level.
package twr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } twr_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } twr_phase_e;
endpackage

// File: rtl/twr_line_sync.sv
// Synchronises SCL and SDA into the core clock and derives edge events.
// Assumes the bus is idle high; start/stop are SDA edges while SCL stays high.
module twr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Metastability chains, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/twr_proto_fsm.sv
// Bus protocol engine: address match, index capture, write commit and read streaming.
// Assumes each SCL edge arrives as a single-cycle event from twr_line_sync.
module twr_proto_fsm
    import twr_pkg::*;
#(
    parameter int NUM_REGS = 6,
    localparam int PW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int CW      = $clog2(BYTE_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_rise,
    input  logic                         scl_fall,
    input  logic                         start_det,
    input  logic                         stop_det,
    input  logic                         sda_s,
    input  logic [6:0]                   dev_addr,
    input  logic [NUM_REGS*BYTE_W-1:0]   rd_bus,
    output logic                         sda_pull,
    output logic                         wr_en,
    output logic [PW-1:0]                wr_idx,
    output logic [BYTE_W-1:0]            wr_data
);
    localparam logic [PW-1:0]     LAST   = PW'(NUM_REGS - 1);
    localparam logic [BYTE_W-1:0] NREG_B = BYTE_W'(NUM_REGS);
    localparam logic [CW-1:0]     FULL   = CW'(BYTE_W);
    localparam logic [CW-1:0]     LASTB  = CW'(BYTE_W - 1);

    twr_state_e          state;
    twr_phase_e          phase;
    logic [CW-1:0]       cnt;
    logic [BYTE_W-1:0]   sh;
    logic [BYTE_W-1:0]   txs;
    logic [PW-1:0]       ptr;
    logic                rw;
    logic                mack;
    logic                ack_drive;
    logic [PW-1:0]       nxt_ptr;
    logic [BYTE_W-1:0]   cur_byte;
    logic [BYTE_W-1:0]   nxt_byte;

    // Saturating pointer step and read-back byte selection.
    always_comb begin
        nxt_ptr  = (ptr == LAST) ? ptr : ptr + 1'b1;
        cur_byte = rd_bus[int'(ptr) * BYTE_W +: BYTE_W];
        nxt_byte = rd_bus[int'(nxt_ptr) * BYTE_W +: BYTE_W];
    end

    // Open-drain request: acknowledge slots, or a zero bit while transmitting.
    assign sda_pull = ack_drive | ((state == ST_TX) & ~txs[BYTE_W-1]);

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            cnt       <= '0;
            sh        <= '0;
            txs       <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            ack_drive <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state     <= ST_IDLE;
                ack_drive <= 1'b0;
            end else if (start_det) begin
                state     <= ST_RX;
                phase     <= PH_ADDR;
                cnt       <= '0;
                ack_drive <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (sh[BYTE_W-1:1] == dev_addr) begin
                                        rw        <= sh[0];
                                        ack_drive <= 1'b1;
                                        state     <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_SUB: begin
                                    if (sh < NREG_B) begin
                                        ptr       <= sh[PW-1:0];
                                        ack_drive <= 1'b1;
                                        state     <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                default: begin
                                    ack_drive <= 1'b1;
                                    state     <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise && phase == PH_DATA) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= sh;
                        end else if (scl_fall) begin
                            ack_drive <= 1'b0;
                            cnt       <= '0;
                            if (phase == PH_ADDR && rw) begin
                                state <= ST_TX;
                                txs   <= cur_byte;
                            end else if (phase == PH_ADDR) begin
                                state <= ST_RX;
                                phase <= PH_SUB;
                            end else if (phase == PH_SUB) begin
                                state <= ST_RX;
                                phase <= PH_DATA;
                            end else begin
                                state <= ST_RX;
                                ptr   <= nxt_ptr;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LASTB) begin
                                state <= ST_MACK;
                                cnt   <= '0;
                            end else begin
                                txs <= {txs[BYTE_W-2:0], 1'b1};
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                ptr   <= nxt_ptr;
                                txs   <= nxt_byte;
                                state <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: a stop always lands in idle on the next cycle.
    a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R7: a start always restarts address reception from bit zero.
    a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_RX && phase == PH_ADDR && cnt == '0));

    // R6: the register index never leaves the valid range.
    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R3: an idle slave never holds the data line.
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R2: register writes come only from a data-byte acknowledge slot.
    a_r2_write_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == ST_ACK && $past(phase) == PH_DATA));

    // R4: the data line request moves only after SCL falls or a bus condition.
    a_r4_pull_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));
endmodule

// File: rtl/twr_regbank.sv
// Bank of byte registers written by index, all contents exposed in parallel.
// Assumes the write index is always in range (guarded by the protocol engine).
module twr_regbank
    import twr_pkg::*;
#(
    parameter int NUM_REGS = 6,
    localparam int PW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PW-1:0]              wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [BYTE_W-1:0] r;

        // Hold or load one register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en && wr_idx == PW'(g)) begin
                r <= wr_data;
            end
        end

        assign q[g*BYTE_W +: BYTE_W] = r;
    end

    // R2: contents change only on a write strobe.
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // R3: no write strobe may name a register that does not exist.
    a_r3_index_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));
endmodule

// File: rtl/twowire_ctl_slave.sv
// Top level: two-wire slave giving indexed access to a bank of control registers.
// Assumes SCL/SDA phases span several core clocks; no clock stretching is done.
module twowire_ctl_slave
    import twr_pkg::*;
#(
    parameter int          NUM_REGS    = 6,
    parameter int          SYNC_STAGES = 2,
    parameter logic [4:0]  ADDR_HI     = 5'b10000,
    localparam int         PW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int         BUS_W       = NUM_REGS * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             strap_hi,
    input  logic             strap_lo,
    input  logic [BUS_W-1:0] rd_bus,
    output logic             sda_pull,
    output logic [BUS_W-1:0] reg_bus
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [PW-1:0]     wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [6:0]        dev_addr;

    assign dev_addr = {ADDR_HI, strap_hi, strap_lo};

    twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twr_proto_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .dev_addr  (dev_addr),
        .rd_bus    (rd_bus),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    twr_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .q       (reg_bus)
    );
endmodule

// File: tb/tb_twowire_ctl_slave.sv
// Bench: bus master model with directed corners and seeded random transfers.
module tb_twowire_ctl_slave;
    localparam int NREG = 6;
    localparam int H    = 10;
    localparam int Q    = 5;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        st_hi = 1'b0;
    logic        st_lo = 1'b0;
    logic [47:0] rd_bus;
    logic        sda_pull;
    logic [47:0] reg_bus;
    logic        sda_line;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  model [NREG];
    logic [7:0]  rb    [NREG];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    twowire_ctl_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .strap_hi (st_hi),
        .strap_lo (st_lo),
        .rd_bus   (rd_bus),
        .sda_pull (sda_pull),
        .reg_bus  (reg_bus)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] dev(input logic h, input logic l);
        return {5'b10000, h, l};
    endfunction

    function automatic int clampi(input int i);
        return (i > NREG - 1) ? NREG - 1 : i;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; waitc(H);
        m_scl = 1'b1; waitc(H);
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b1; waitc(H);
        m_sda = 1'b1; waitc(H);
    endtask

    task automatic put_bit(input logic b);
        waitc(Q);
        m_sda = b; waitc(H - Q);
        m_scl = 1'b1; waitc(H);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; waitc(H);
        m_scl = 1'b1; waitc(H / 2);
        b = sda_line; waitc(H - H / 2);
        m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            check({req, " reg_bus"}, 32'(reg_bus[i*8 +: 8]), 32'(model[i]));
    endtask

    // Write n random bytes from index sub; checks acks and the commit per byte.
    task automatic do_write(input logic [6:0] a, input int sub, input int n, input string req);
        logic       ack;
        logic [7:0] d;
        int         idx;
        bus_start();
        put_byte({a, 1'b0}, ack); check({req, " address ack"}, 32'(ack), 1);
        put_byte(8'(sub), ack);   check({req, " index ack"}, 32'(ack), 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            put_byte(d, ack);
            check({req, " data ack"}, 32'(ack), 1);
            idx = clampi(sub + k);
            model[idx] = d;
            check({req, " committed at ack"}, 32'(reg_bus[idx*8 +: 8]), 32'(d));
        end
        bus_stop();
        check_regs(req);
    endtask

    // Set index sub, repeated start, read n bytes with NACK on the last.
    task automatic do_read(input logic [6:0] a, input int sub, input int n, input string req);
        logic       ack;
        logic [7:0] v;
        bus_start();
        put_byte({a, 1'b0}, ack); check({req, " address ack"}, 32'(ack), 1);
        put_byte(8'(sub), ack);   check({req, " index ack"}, 32'(ack), 1);
        bus_start();
        put_byte({a, 1'b1}, ack); check({req, " read address ack"}, 32'(ack), 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, v);
            check({req, " read byte"}, 32'(v), 32'(rb[clampi(sub + k)]));
        end
        waitc(Q);
        check({req, " released after NACK"}, 32'(sda_pull), 0);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) begin
            model[i] = 8'h00;
            rb[i]    = 8'($urandom);
        end
        rb[4] = 8'hA5;
        rb[5] = 8'h3C;
        for (int i = 0; i < NREG; i++) rd_bus[i*8 +: 8] = rb[i];

        waitc(5);
        // R9: reset state
        check("R9 sda released in reset", 32'(sda_pull), 0);
        rst_n = 1'b1;
        waitc(5);
        check_regs("R9 reset value");
        check("R9 sda released", 32'(sda_pull), 0);
        // R9: index 0 after reset, read without a prior write phase
        bus_start();
        put_byte({dev(0, 0), 1'b1}, ack); check("R9 read address ack", 32'(ack), 1);
        get_byte(1'b0, v);
        check("R9 index starts at 0", 32'(v), 32'(rb[0]));
        bus_stop();

        // R1: non-matching addresses (strap bit and fixed bits wrong)
        bus_start();
        put_byte({7'h41, 1'b0}, ack); check("R1 wrong strap no ack", 32'(ack), 0);
        put_byte(8'h00, ack);         check("R1 ignored after mismatch", 32'(ack), 0);
        bus_stop();
        bus_start();
        put_byte({7'h44, 1'b0}, ack); check("R1 wrong fixed bits no ack", 32'(ack), 0);
        bus_stop();
        check_regs("R1 nothing written");
        // R1: every strap setting
        for (int s = 0; s < 4; s++) begin
            st_hi = s[1];
            st_lo = s[0];
            waitc(4);
            do_write(dev(s[1], s[0]), s, 1, "R1 strap address");
        end
        st_hi = 1'b0;
        st_lo = 1'b1;

        // R2: multi-byte autoincrement write
        do_write(dev(0, 1), 1, 3, "R2 autoincrement write");

        // R3: invalid indices
        bus_start();
        put_byte({dev(0, 1), 1'b0}, ack); check("R3 address ack", 32'(ack), 1);
        put_byte(8'd6, ack);              check("R3 index 6 NACK", 32'(ack), 0);
        put_byte(8'h5A, ack);             check("R3 data after NACK ignored", 32'(ack), 0);
        bus_stop();
        bus_start();
        put_byte({dev(0, 1), 1'b0}, ack);
        put_byte(8'd200, ack);            check("R3 index 200 NACK", 32'(ack), 0);
        bus_stop();
        check_regs("R3 no register changed");

        // R6: write past the top
        do_write(dev(0, 1), 4, 4, "R6 write saturates");

        // R4 and R5: reads
        do_read(dev(0, 1), 2, 3, "R4 streamed read");
        do_read(dev(0, 1), 4, 5, "R5 read past top");

        // R7: stop inside a data byte
        bus_start();
        put_byte({dev(0, 1), 1'b0}, ack);
        put_byte(8'd0, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        check("R7 released after stop", 32'(sda_pull), 0);
        check_regs("R7 partial byte discarded");
        // R7: start inside an address byte restarts reception
        bus_start();
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        do_write(dev(0, 1), 0, 2, "R7 restart after early start");

        // R8: stop then start in one SCL high period
        bus_start();
        put_byte({dev(0, 1), 1'b0}, ack);
        put_byte(8'd3, ack);
        v = 8'h96;
        put_byte(v, ack); check("R8 data ack", 32'(ack), 1);
        model[3] = v;
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b1; waitc(H);
        m_sda = 1'b1; waitc(H);
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b0; waitc(Q);
        put_byte({dev(0, 1), 1'b0}, ack); check("R8 address ack after stop-start", 32'(ack), 1);
        put_byte(8'd5, ack);              check("R8 index ack", 32'(ack), 1);
        v = 8'h69;
        put_byte(v, ack);                 check("R8 data ack after stop-start", 32'(ack), 1);
        model[5] = v;
        bus_stop();
        check_regs("R8 registers");

        // R2 R4 R5 R6: seeded random mix
        for (int t = 0; t < 24; t++) begin
            int sub;
            int n;
            sub = int'($urandom_range(NREG - 1, 0));
            n   = int'($urandom_range(5, 1));
            if ($urandom_range(1, 0) == 0) do_write(dev(0, 1), sub, n, "R2 R6 random write");
            else                            do_read(dev(0, 1), sub, n, "R4 R5 random read");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule